// File: doc/BRIEF.md
# Fast privileged call/return sequencer

This block carries out the control-state changes of a fast kernel entry and the matching fast user return in a small protected-mode processor model. Software first fills three model-specific registers through a simple address/data/write-enable port: a base code selector, a kernel entry pointer and a kernel stack pointer. An entry request then loads the code selector, instruction pointer, stack selector and stack pointer and drops the current privilege level to 0. A return request takes the user instruction pointer and user stack pointer from two general-purpose register inputs and raises the privilege level to 3. No value is pushed to any stack.

All four segment selectors are derived from the one base selector at fixed 8-byte descriptor strides. Each segment-register load issues one descriptor read over a request/acknowledge handshake, code segment first and stack segment second. The descriptor table, the memory and the instruction decoder live outside the block. A request that is not legal in the current mode or privilege level produces a one-cycle fault pulse and changes nothing.

Top module: `fastcall_seq`

## Requirements
- R1: MSR writes take effect when `msr_we` is high: address 0 holds the base code selector (low 16 bits of `msr_wdata`), address 1 the kernel entry pointer, address 2 the kernel stack pointer; writes to address 3 change nothing.
- R2: A legal entry loads `seg_cs` with the base selector, `ins_ptr` with the entry pointer, `seg_ss` with base + 8 and `stk_ptr` with the kernel stack pointer.
- R3: When an entry completes, `cpl` becomes 0 and `vm86` becomes 0.
- R4: A legal return loads `seg_cs` with (base + 16) and `seg_ss` with (base + 24), each with bits 1:0 forced to 3, `ins_ptr` with `gpr_edx`, `stk_ptr` with `gpr_ecx`, and sets `cpl` to 3.
- R5: An entry is illegal when `prot_en` is 0 or when bits 15:2 of the base code selector are all zero; a return is legal only when `prot_en` is 1, `vm86` is 0 and `cpl` is 0.
- R6: A legal request makes exactly two descriptor reads: `desc_sel` first carries the new code selector, then the new stack selector, and it is zero when `desc_req` is low. Each read holds `desc_req` and `desc_sel` until `desc_ack`; `seg_cs`/`ins_ptr` update one cycle after the first acknowledge, `seg_ss`/`stk_ptr`/`cpl`/`vm86` one cycle after the second.
- R7: An illegal request gives `fault` high for exactly the next cycle, issues no descriptor read and leaves the segment, pointer and privilege outputs unchanged.
- R8: `busy` is high from the cycle after a legal request until the cycle after the second acknowledge; requests arriving while `busy` is high are ignored.
- R9: When `enter_req` and `leave_req` are high together, the entry is taken and the return is dropped.
- R10: A pulse on `vm86_set` sets `vm86` in the following cycle.
- R11: The MSR values and the `gpr_edx`/`gpr_ecx` values are captured in the request cycle; changes to them while `busy` is high do not alter the result.
- R12: After reset all segment and pointer outputs are zero, `cpl` is 0, `vm86` is 0, and `busy`, `fault` and `desc_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msr_we | input | 1 | MSR write enable |
| msr_addr | input | 2 | MSR index (0 code selector, 1 entry pointer, 2 stack pointer) |
| msr_wdata | input | 32 | MSR write data |
| prot_en | input | 1 | Protection enable; 0 means real mode |
| enter_req | input | 1 | Fast kernel entry request |
| leave_req | input | 1 | Fast user return request |
| vm86_set | input | 1 | Sets the virtual-8086 flag |
| gpr_edx | input | 32 | User return instruction pointer |
| gpr_ecx | input | 32 | User return stack pointer |
| desc_req | output | 1 | Descriptor read request |
| desc_sel | output | 16 | Selector of the descriptor to read |
| desc_ack | input | 1 | Descriptor read acknowledge |
| busy | output | 1 | Transition in progress |
| fault | output | 1 | One-cycle illegal-request pulse |
| seg_cs | output | 16 | Code segment selector |
| ins_ptr | output | 32 | Instruction pointer |
| seg_ss | output | 16 | Stack segment selector |
| stk_ptr | output | 32 | Stack pointer |
| cpl | output | 2 | Current privilege level |
| vm86 | output | 1 | Virtual-8086 flag |

## Verification
A wrong sequencer state shows at the handshake at once: a skipped or repeated descriptor read, or a selector that changes before its acknowledge, is visible on `desc_req`/`desc_sel` in the very next cycle. Wrong captured operands or a wrong selector offset appear on the segment and pointer outputs one cycle after the matching acknowledge, and a wrong legality decision appears one cycle after the request either as a missing or spurious `fault` pulse or as a `busy` that rises when it should not. Privilege and flag errors show on `cpl` and `vm86` one cycle after the second acknowledge and then persist, so the next request's legality also goes wrong.

// File: rtl/fc_pkg.sv
package fc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_GET_CS = 2'd1,
      ST_GET_SS = 2'd2
   } fc_state_e;

   typedef enum logic {
      OP_ENTER = 1'b0,
      OP_LEAVE = 1'b1
   } fc_op_e;

   localparam int unsigned MSR_IDX_CODE_SEL  = 0;
   localparam int unsigned MSR_IDX_ENTRY_PTR = 1;
   localparam int unsigned MSR_IDX_STACK_PTR = 2;

   localparam logic [1:0] PRIV_KERNEL = 2'd0;
   localparam logic [1:0] PRIV_USER   = 2'd3;

endpackage

// File: rtl/fc_msr_bank.sv
module fc_msr_bank #(
   parameter int SEL_W = 16,
   parameter int PTR_W = 32,
   parameter int AW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [PTR_W-1:0] wdata,
   output logic [SEL_W-1:0] code_sel,
   output logic [PTR_W-1:0] entry_ptr,
   output logic [PTR_W-1:0] stack_ptr
);
   import fc_pkg::*;

   localparam int NPTR = 2;

   if (SEL_W > PTR_W) begin : g_bad_sel
      $error("SEL_W must not exceed PTR_W");
   end
   if ((1 << AW) < 3) begin : g_bad_aw
      $error("AW too small for three MSRs");
   end

   logic [SEL_W-1:0] sel_q;
   logic [PTR_W-1:0] ptr_q [NPTR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                             sel_q <= '0;
      else if (we && addr == AW'(MSR_IDX_CODE_SEL))           sel_q <= wdata[SEL_W-1:0];
   end

   for (genvar i = 0; i < NPTR; i++) begin : g_ptr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                          ptr_q[i] <= '0;
         else if (we && addr == AW'(MSR_IDX_ENTRY_PTR + i))   ptr_q[i] <= wdata;
      end
   end

   assign code_sel  = sel_q;
   assign entry_ptr = ptr_q[MSR_IDX_ENTRY_PTR - 1];
   assign stack_ptr = ptr_q[MSR_IDX_STACK_PTR - 1];

endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl #(
   parameter int SEL_W         = 16,
   parameter int PTR_W         = 32,
   parameter int DESC_BYTES    = 8,
   parameter bit CHECK_NULL_SEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enter_req,
   input  logic             leave_req,
   input  logic             prot_en,
   input  logic             vm86,
   input  logic [1:0]       cpl,
   input  logic [SEL_W-1:0] code_sel,
   input  logic [PTR_W-1:0] entry_ptr,
   input  logic [PTR_W-1:0] stack_ptr,
   input  logic [PTR_W-1:0] gpr_edx,
   input  logic [PTR_W-1:0] gpr_ecx,
   input  logic             desc_ack,
   output logic             desc_req,
   output logic [SEL_W-1:0] desc_sel,
   output logic             busy,
   output logic             fault,
   output logic             ld_cs,
   output logic             ld_ss,
   output logic [SEL_W-1:0] new_cs,
   output logic [SEL_W-1:0] new_ss,
   output logic [PTR_W-1:0] new_ip,
   output logic [PTR_W-1:0] new_sp,
   output logic [1:0]       new_cpl,
   output logic             clr_vm
);
   import fc_pkg::*;

   localparam int RPL_W = 2;
   localparam logic [SEL_W-1:0] OFS_KSTK = SEL_W'(DESC_BYTES);
   localparam logic [SEL_W-1:0] OFS_UCS  = SEL_W'(2 * DESC_BYTES);
   localparam logic [SEL_W-1:0] OFS_USTK = SEL_W'(3 * DESC_BYTES);
   localparam logic [SEL_W-1:0] RPL_USER = SEL_W'(PRIV_USER);

   if (SEL_W < 8) begin : g_bad_selw
      $error("SEL_W too small");
   end
   if (DESC_BYTES < 4 || (DESC_BYTES & (DESC_BYTES - 1)) != 0) begin : g_bad_stride
      $error("DESC_BYTES must be a power of two, at least 4");
   end

   fc_state_e        state_q, state_d;
   fc_op_e           op_q;
   logic [SEL_W-1:0] base_q;
   logic [PTR_W-1:0] ip_q, sp_q;
   logic             fault_q;
   logic             null_sel, enter_ok, leave_ok, idle;
   logic             take_enter, take_leave, bad_req;

   if (CHECK_NULL_SEL) begin : g_null_chk
      assign null_sel = (code_sel[SEL_W-1:RPL_W] == '0);
   end else begin : g_no_null_chk
      assign null_sel = 1'b0;
   end

   assign idle       = (state_q == ST_IDLE);
   assign enter_ok   = prot_en && !null_sel;
   assign leave_ok   = prot_en && !vm86 && (cpl == PRIV_KERNEL);
   assign take_enter = idle && enter_req && enter_ok;
   assign take_leave = idle && !enter_req && leave_req && leave_ok;
   assign bad_req    = idle && ((enter_req && !enter_ok) ||
                                (!enter_req && leave_req && !leave_ok));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (take_enter || take_leave) state_d = ST_GET_CS;
         ST_GET_CS: if (desc_ack)                 state_d = ST_GET_SS;
         ST_GET_SS: if (desc_ack)                 state_d = ST_IDLE;
         default:                                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_ENTER;
         base_q  <= '0;
         ip_q    <= '0;
         sp_q    <= '0;
         fault_q <= 1'b0;
      end else begin
         state_q <= state_d;
         fault_q <= bad_req;
         if (take_enter) begin
            op_q   <= OP_ENTER;
            base_q <= code_sel;
            ip_q   <= entry_ptr;
            sp_q   <= stack_ptr;
         end else if (take_leave) begin
            op_q   <= OP_LEAVE;
            base_q <= code_sel;
            ip_q   <= gpr_edx;
            sp_q   <= gpr_ecx;
         end
      end
   end

   always_comb begin
      if (op_q == OP_ENTER) begin
         new_cs  = base_q;
         new_ss  = base_q + OFS_KSTK;
         new_cpl = PRIV_KERNEL;
      end else begin
         new_cs  = (base_q + OFS_UCS)  | RPL_USER;
         new_ss  = (base_q + OFS_USTK) | RPL_USER;
         new_cpl = PRIV_USER;
      end
   end

   assign new_ip   = ip_q;
   assign new_sp   = sp_q;
   assign clr_vm   = (op_q == OP_ENTER);
   assign busy     = !idle;
   assign fault    = fault_q;
   assign desc_req = (state_q == ST_GET_CS) || (state_q == ST_GET_SS);
   assign desc_sel = (state_q == ST_GET_CS) ? new_cs :
                     (state_q == ST_GET_SS) ? new_ss : '0;
   assign ld_cs    = (state_q == ST_GET_CS) && desc_ack;
   assign ld_ss    = (state_q == ST_GET_SS) && desc_ack;

   // R6: an unacknowledged read keeps its request and selector
   p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      desc_req && !desc_ack |=> desc_req && $stable(desc_sel));

   // R6: the code-segment read is always followed by the stack-segment read
   p_cs_then_ss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cs |=> desc_req && !ld_cs);

   // R8: the block goes idle right after the second acknowledge
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ss |=> !busy);

   // R7: a fault never starts a descriptor read
   p_fault_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !desc_req);

endmodule

// File: rtl/fc_arch_regs.sv
module fc_arch_regs #(
   parameter int SEL_W = 16,
   parameter int PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_cs,
   input  logic             ld_ss,
   input  logic [SEL_W-1:0] new_cs,
   input  logic [SEL_W-1:0] new_ss,
   input  logic [PTR_W-1:0] new_ip,
   input  logic [PTR_W-1:0] new_sp,
   input  logic [1:0]       new_cpl,
   input  logic             clr_vm,
   input  logic             vm86_set,
   output logic [SEL_W-1:0] seg_cs,
   output logic [PTR_W-1:0] ins_ptr,
   output logic [SEL_W-1:0] seg_ss,
   output logic [PTR_W-1:0] stk_ptr,
   output logic [1:0]       cpl,
   output logic             vm86
);
   logic [SEL_W-1:0] cs_q, ss_q;
   logic [PTR_W-1:0] ip_q, sp_q;
   logic [1:0]       cpl_q;
   logic             vm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= '0;
         ip_q <= '0;
      end else if (ld_cs) begin
         cs_q <= new_cs;
         ip_q <= new_ip;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ss_q  <= '0;
         sp_q  <= '0;
         cpl_q <= 2'd0;
      end else if (ld_ss) begin
         ss_q  <= new_ss;
         sp_q  <= new_sp;
         cpl_q <= new_cpl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                vm_q <= 1'b0;
      else if (ld_ss && clr_vm)  vm_q <= 1'b0;
      else if (vm86_set)         vm_q <= 1'b1;
   end

   assign seg_cs  = cs_q;
   assign ins_ptr = ip_q;
   assign seg_ss  = ss_q;
   assign stk_ptr = sp_q;
   assign cpl     = cpl_q;
   assign vm86    = vm_q;

   // R3: privilege level moves only with the stack-segment load
   p_cpl_only_on_ss_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_ss |=> $stable(cpl_q));

   // R6: code segment and instruction pointer move only on the first load
   p_cs_only_on_ld_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_cs |=> $stable(cs_q) && $stable(ip_q));

   // R10: a set request without a clearing commit raises the flag
   p_vm_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      vm86_set && !ld_ss |=> vm_q);

endmodule

// File: rtl/fastcall_seq.sv
module fastcall_seq #(
   parameter int SEL_W          = 16,
   parameter int PTR_W          = 32,
   parameter int MSR_AW         = 2,
   parameter int DESC_BYTES     = 8,
   parameter bit CHECK_NULL_SEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msr_we,
   input  logic [MSR_AW-1:0] msr_addr,
   input  logic [PTR_W-1:0] msr_wdata,
   input  logic             prot_en,
   input  logic             enter_req,
   input  logic             leave_req,
   input  logic             vm86_set,
   input  logic [PTR_W-1:0] gpr_edx,
   input  logic [PTR_W-1:0] gpr_ecx,
   output logic             desc_req,
   output logic [SEL_W-1:0] desc_sel,
   input  logic             desc_ack,
   output logic             busy,
   output logic             fault,
   output logic [SEL_W-1:0] seg_cs,
   output logic [PTR_W-1:0] ins_ptr,
   output logic [SEL_W-1:0] seg_ss,
   output logic [PTR_W-1:0] stk_ptr,
   output logic [1:0]       cpl,
   output logic             vm86
);
   localparam logic [SEL_W-1:0] STRIDE = SEL_W'(DESC_BYTES);

   logic [SEL_W-1:0] code_sel;
   logic [PTR_W-1:0] entry_ptr, stack_ptr;
   logic             ld_cs, ld_ss, clr_vm;
   logic [SEL_W-1:0] new_cs, new_ss;
   logic [PTR_W-1:0] new_ip, new_sp;
   logic [1:0]       new_cpl;

   fc_msr_bank #(.SEL_W(SEL_W), .PTR_W(PTR_W), .AW(MSR_AW)) u_msr (
      .clk(clk), .rst_n(rst_n), .we(msr_we), .addr(msr_addr), .wdata(msr_wdata),
      .code_sel(code_sel), .entry_ptr(entry_ptr), .stack_ptr(stack_ptr)
   );

   fc_ctrl #(.SEL_W(SEL_W), .PTR_W(PTR_W), .DESC_BYTES(DESC_BYTES),
             .CHECK_NULL_SEL(CHECK_NULL_SEL)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .leave_req(leave_req),
      .prot_en(prot_en), .vm86(vm86), .cpl(cpl), .code_sel(code_sel),
      .entry_ptr(entry_ptr), .stack_ptr(stack_ptr), .gpr_edx(gpr_edx),
      .gpr_ecx(gpr_ecx), .desc_ack(desc_ack), .desc_req(desc_req),
      .desc_sel(desc_sel), .busy(busy), .fault(fault), .ld_cs(ld_cs),
      .ld_ss(ld_ss), .new_cs(new_cs), .new_ss(new_ss), .new_ip(new_ip),
      .new_sp(new_sp), .new_cpl(new_cpl), .clr_vm(clr_vm)
   );

   fc_arch_regs #(.SEL_W(SEL_W), .PTR_W(PTR_W)) u_arch (
      .clk(clk), .rst_n(rst_n), .ld_cs(ld_cs), .ld_ss(ld_ss),
      .new_cs(new_cs), .new_ss(new_ss), .new_ip(new_ip), .new_sp(new_sp),
      .new_cpl(new_cpl), .clr_vm(clr_vm), .vm86_set(vm86_set),
      .seg_cs(seg_cs), .ins_ptr(ins_ptr), .seg_ss(seg_ss), .stk_ptr(stk_ptr),
      .cpl(cpl), .vm86(vm86)
   );

   // R7: a fault cycle follows a cycle with no architectural change
   p_fault_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $stable(seg_cs) && $stable(ins_ptr) && $stable(seg_ss)
                && $stable(stk_ptr) && $stable(cpl));

   // R8: fault and busy never overlap
   p_fault_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !busy);

   // R2: after any completed transition the stack selector sits one descriptor above code
   p_ss_stride_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> seg_ss == seg_cs + STRIDE);

   // R4: a completed return leaves user-level selectors
   p_user_rpl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && cpl == 2'd3 |-> seg_cs[1:0] == 2'd3 && seg_ss[1:0] == 2'd3);

   // R3: a completed entry leaves the virtual-8086 flag clear
   p_kernel_no_vm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && cpl == 2'd0 |-> !vm86);

endmodule

// File: tb/tb_fastcall_seq.sv
`timescale 1ns/1ps
module tb_fastcall_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msr_we = 1'b0;
   logic [1:0]  msr_addr = '0;
   logic [31:0] msr_wdata = '0;
   logic        prot_en = 1'b0;
   logic        enter_req = 1'b0, leave_req = 1'b0, vm86_set = 1'b0;
   logic [31:0] gpr_edx = '0, gpr_ecx = '0;
   logic        desc_ack = 1'b0;
   logic        desc_req, busy, fault, vm86;
   logic [15:0] desc_sel, seg_cs, seg_ss;
   logic [31:0] ins_ptr, stk_ptr;
   logic [1:0]  cpl;

   fastcall_seq dut (
      .clk(clk), .rst_n(rst_n), .msr_we(msr_we), .msr_addr(msr_addr),
      .msr_wdata(msr_wdata), .prot_en(prot_en), .enter_req(enter_req),
      .leave_req(leave_req), .vm86_set(vm86_set), .gpr_edx(gpr_edx),
      .gpr_ecx(gpr_ecx), .desc_req(desc_req), .desc_sel(desc_sel),
      .desc_ack(desc_ack), .busy(busy), .fault(fault), .seg_cs(seg_cs),
      .ins_ptr(ins_ptr), .seg_ss(seg_ss), .stk_ptr(stk_ptr), .cpl(cpl),
      .vm86(vm86)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   string cur_tag = "R12";

   // reference model state
   logic [15:0] m_sel = '0;
   logic [31:0] m_eip = '0, m_esp = '0;
   logic        e_busy = 0, e_fault = 0, e_dreq = 0, e_vm = 0;
   logic [15:0] e_dsel = '0, e_cs = '0, e_ss = '0;
   logic [31:0] e_ip = '0, e_sp = '0;
   logic [1:0]  e_cpl = '0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // per-clock comparison of every output against the model
   always @(negedge clk) begin
      n_chk++;
      if ({busy, fault, desc_req, desc_sel, seg_cs, ins_ptr, seg_ss, stk_ptr, cpl, vm86} !==
          {e_busy, e_fault, e_dreq, e_dsel, e_cs, e_ip, e_ss, e_sp, e_cpl, e_vm}) begin
         n_bad++;
         $display("FAIL %s act=b%0b f%0b r%0b sel=%h cs=%h ip=%h ss=%h sp=%h cpl=%0d vm=%0b exp=b%0b f%0b r%0b sel=%h cs=%h ip=%h ss=%h sp=%h cpl=%0d vm=%0b",
                  cur_tag, busy, fault, desc_req, desc_sel, seg_cs, ins_ptr, seg_ss, stk_ptr, cpl, vm86,
                  e_busy, e_fault, e_dreq, e_dsel, e_cs, e_ip, e_ss, e_sp, e_cpl, e_vm);
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic msr_wr(logic [1:0] a, logic [31:0] d);
      msr_we = 1; msr_addr = a; msr_wdata = d;
      step();
      msr_we = 0;
      if (a == 2'd0) m_sel = d[15:0];
      else if (a == 2'd1) m_eip = d;
      else if (a == 2'd2) m_esp = d;
   endtask

   task automatic set_vm();
      vm86_set = 1;
      step();
      vm86_set = 0;
      e_vm = 1;
   endtask

   // is_enter: entry else return; both: raise both requests; waits: cycles before each ack;
   // disturb: in the first wait cycle change operands and raise ignored requests
   task automatic run_op(bit is_enter, bit both, int waits, bit disturb, string tag);
      logic        legal;
      logic [15:0] cs_t, ss_t;
      logic [31:0] ip_t, sp_t;
      cur_tag = tag;
      if (is_enter) begin
         legal = prot_en && (m_sel[15:2] != 0);
         cs_t = m_sel; ss_t = m_sel + 16'd8; ip_t = m_eip; sp_t = m_esp;
      end else begin
         legal = prot_en && !e_vm && (e_cpl == 2'd0);
         cs_t = (m_sel + 16'd16) | 16'd3; ss_t = (m_sel + 16'd24) | 16'd3;
         ip_t = gpr_edx; sp_t = gpr_ecx;
      end
      enter_req = is_enter || both;
      leave_req = !is_enter || both;
      step();
      enter_req = 0; leave_req = 0;
      if (!legal) begin
         e_fault = 1;
         step();
         e_fault = 0;
         return;
      end
      e_busy = 1; e_dreq = 1; e_dsel = cs_t;
      for (int i = 0; i < waits; i++) begin
         if (disturb && i == 0) begin
            enter_req = 1; leave_req = 1;
            gpr_edx = ~gpr_edx; gpr_ecx = ~gpr_ecx;
            msr_we = 1; msr_addr = 2'd1; msr_wdata = m_eip ^ 32'h00FF_FF00;
            step();
            m_eip = msr_wdata;
            msr_we = 0; enter_req = 0; leave_req = 0;
         end else begin
            step();
         end
      end
      desc_ack = 1;
      step();
      desc_ack = 0;
      e_cs = cs_t; e_ip = ip_t; e_dsel = ss_t;
      for (int i = 0; i < waits; i++) step();
      desc_ack = 1;
      step();
      desc_ack = 0;
      e_ss = ss_t; e_sp = sp_t; e_busy = 0; e_dreq = 0; e_dsel = '0;
      e_cpl = is_enter ? 2'd0 : 2'd3;
      if (is_enter) e_vm = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1;
      step();
      // R12: reset state
      chk("R12 reset cs/ip", {seg_cs, ins_ptr}, 64'h0);
      chk("R12 reset flags", {busy, fault, desc_req, cpl, vm86}, 64'h0);

      // R1: MSR programming, address 3 ignored
      cur_tag = "R1";
      msr_wr(2'd0, 32'h0000_0010);
      msr_wr(2'd1, 32'h8000_1000);
      msr_wr(2'd2, 32'h9000_0F00);
      msr_wr(2'd3, 32'hDEAD_BEEF);
      prot_en = 1;

      // R10: set virtual-8086 flag
      cur_tag = "R10";
      set_vm();
      chk("R10 vm86 set", vm86, 1);

      // R2 R3 R6 R8 R11: entry with wait states and disturbance while busy
      run_op(1, 0, 2, 1, "R2 R3 R6 R8 R11 entry");
      chk("R11 entry ptr captured", ins_ptr, 32'h8000_1000);
      chk("R2 kernel ss", seg_ss, 16'h0018);
      chk("R3 cpl/vm after entry", {cpl, vm86}, {2'd0, 1'b0});

      // R4 R11: return with operands changed mid-flight
      gpr_edx = 32'h0040_2000; gpr_ecx = 32'h7FFF_0000;
      run_op(0, 0, 1, 1, "R4 R11 return");
      chk("R4 user cs", seg_cs, 16'h0023);
      chk("R4 user ss", seg_ss, 16'h002B);
      chk("R4 user ip/sp", {ins_ptr, stk_ptr}, {32'h0040_2000, 32'h7FFF_0000});

      // R5 R7: return from privilege 3 faults
      run_op(0, 0, 0, 0, "R5 R7 return at cpl3");
      chk("R7 state kept", {seg_cs, cpl}, {16'h0023, 2'd3});

      // R5: entry in real mode faults
      prot_en = 0;
      run_op(1, 0, 0, 0, "R5 R7 entry real mode");
      prot_en = 1;

      // R5: null code selector faults
      cur_tag = "R1";
      msr_wr(2'd0, 32'h0000_0003);
      run_op(1, 0, 0, 0, "R5 R7 null selector");
      chk("R5 cpl unchanged", cpl, 2'd3);

      // R9: simultaneous requests take the entry
      cur_tag = "R1";
      msr_wr(2'd0, 32'h0000_0043);
      run_op(1, 1, 0, 0, "R9 R2 both requests");
      chk("R9 entry taken", {seg_cs, cpl}, {16'h0043, 2'd0});

      // R5: return with virtual-8086 flag set faults
      cur_tag = "R10";
      set_vm();
      run_op(0, 0, 0, 0, "R5 R7 return in vm86");

      // R3 R4: entry clears the flag, then a legal return
      run_op(1, 0, 1, 0, "R3 R6 entry clears vm86");
      chk("R3 vm86 cleared", vm86, 0);
      gpr_edx = 32'h1234_5678; gpr_ecx = 32'h0BAD_F00D;
      run_op(0, 0, 0, 0, "R4 R6 return");
      chk("R4 return sel", {seg_cs, seg_ss}, {16'h0053, 16'h005B});

      step(); step();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule